// File: doc/BRIEF.md
# Four-Stage Shift Register with JK First Stage

This block is a four-bit register. It takes data either as a whole parallel word or as a serial stream. A mode input is sampled on each rising clock edge. When the mode input is high, all four stages load a parallel word. When it is low, the stages shift toward the high end. In shift mode the lowest stage takes its next value from a J input and an active-low K input, using JK rules. Driving J and the inverted-K input with the same signal makes that stage behave as a plain D flip-flop.

An output-polarity input acts combinationally on the outputs. It shows either the stored bits or their inverse, and it does not wait for a clock edge. An active-high asynchronous reset clears every stage at once. Typical uses are counters, sequence generators, serial-to-parallel conversion and parallel-to-serial conversion.

Top module: `jk_shift_reg4`

## Requirements
- R1: The register holds four stages. The stored state changes only on a rising clock edge, or while reset is asserted.
- R2: With `load_par` low at a rising edge, stage k+1 takes the old value of stage k, for k = 0, 1, 2. Stage 0 is the first stage, and `q[0]` reflects it.
- R3: With `load_par` high at a rising edge, stage k takes `d[k]` for every k.
- R4: With `load_par` low, the next value of stage 0 is `j & ~s0 | kn & s0`. The four input cases give: `j`=0 and `kn`=1 holds; `j`=1 and `kn`=0 toggles; both high sets; both low clears.
- R5: With `load_par` high, `j` and `kn` have no effect on the next state.
- R6: When `true_out` is 1, `q` equals the stored bits. When it is 0, `q` equals their bitwise inverse. A change of `true_out` reaches `q` without any clock edge.
- R7: When `rst` goes high, all stages clear to 0 at once, with no clock edge needed. While `rst` is high, the state stays 0 whatever the mode or the data inputs. The outputs therefore read 0000 in true mode and 1111 in complement mode.
- R8: Tying `j` and `kn` together turns stage 0 into a D flip-flop that takes the tied value on each shift edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous clear, active high |
| load_par | input | 1 | 1 = parallel load, 0 = serial shift |
| j | input | 1 | J input of stage 0 |
| kn | input | 1 | Active-low K input of stage 0 |
| d | input | 4 | Parallel data; d[k] goes to stage k |
| true_out | input | 1 | 1 = true outputs, 0 = inverted outputs |
| q | output | 4 | Register contents after the polarity select |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the asynchronous clear and a clocked load or shift. The bench raises `rst` between clock edges and holds it across an edge while a load is requested. It then checks that the outputs are all zeros (or all ones) straight away and stay that way. The second pair is the polarity select and the clocked state: the bench flips `true_out` between edges, just after a shift. It checks `q` against a behavioural model before the next edge, so that the flip shows at once while the stored value is left unchanged.

// File: rtl/jk_shift_reg4.sv
module jk_shift_reg4 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_par,
  input  logic         j,
  input  logic         kn,
  input  logic [W-1:0] d,
  input  logic         true_out,
  output logic [W-1:0] q
);

  logic [W-1:0] st;
  logic         first_nx;

  assign first_nx = (j & ~st[0]) | (kn & st[0]);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      st <= '0;
    else if (load_par)
      st <= d;
    else
      st <= {st[W-2:0], first_nx};
  end

  assign q = true_out ? st : ~st;

  // R3
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    load_par |=> (st == $past(d)));

  // R2
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    !load_par |=> (st[W-1:1] == $past(st[W-2:0])));

  // R4
  p_jk_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_par && !j && kn) |=> $stable(st[0]));

  // R4
  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_par && j && !kn) |=> (st[0] != $past(st[0])));

  // R7
  p_clear_r7: assert property (@(posedge clk) rst |-> (st == '0));

  // R6
  always_comb begin
    if (!rst) p_polarity_r6: assert ((q ^ st) == {W{~true_out}});
  end

endmodule

// File: tb/sim_jk_shift_reg4.sv
module sim_jk_shift_reg4;
  logic clk = 0, rst = 1, load_par = 0, j = 0, kn = 0, true_out = 1;
  logic [3:0] d = 0;
  logic [3:0] q;
  int checks = 0, errors = 0;
  logic [3:0] m = 0;

  jk_shift_reg4 u0 (.clk(clk), .rst(rst), .load_par(load_par), .j(j), .kn(kn),
                    .d(d), .true_out(true_out), .q(q));

  always #5 clk = ~clk;

  function automatic logic [3:0] view(input logic [3:0] s, input logic t);
    return t ? s : ~s;
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s q=%b expected=%b", req, q, exp);
    end
  endtask

  // one edge: model update, then sample 3 ns after edge
  task automatic step(input string req, input logic lp, input logic jj, input logic kk,
                      input logic [3:0] dd);
    load_par = lp; j = jj; kn = kk; d = dd;
    @(posedge clk);
    if (rst) m = 0;
    else if (lp) m = dd;
    else begin
      int b0 = m[0];
      int nb = (jj && !b0) || (kk && b0);
      m = {m[2:0], nb[0]};
    end
    #3;
    chk(req, view(m, true_out));
    #2;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog q=%b expected=done", q);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    chk("R7", 4'b0000);
    true_out = 0; #1;
    chk("R7", 4'b1111);
    true_out = 1;
    @(negedge clk); rst = 0;
    step("R3", 1, 0, 0, 4'b1010);
    step("R3", 1, 1, 1, 4'b0101);
    step("R5", 1, 1, 0, 4'b0101);
    step("R2", 0, 0, 1, 4'b0000);
    step("R4", 0, 0, 1, 4'b1111);
    step("R4", 0, 1, 0, 4'b1111);
    step("R4", 0, 1, 0, 4'b0000);
    step("R4", 0, 1, 1, 4'b0000);
    step("R4", 0, 0, 0, 4'b1111);
    for (int i = 0; i < 8; i++) begin
      logic b = (i % 3) == 0;
      step("R8", 0, b, b, 4'b0110);
    end
    for (int i = 0; i < 6; i++) step("R1", 0, 1, 0, 4'b0000);
    step("R3", 1, 0, 0, 4'b1001);
    // R6 polarity flips between edges
    #1 true_out = 0; #1 chk("R6", ~m);
    step("R2", 0, 1, 1, 4'b0000);
    true_out = 1; #1 chk("R6", m);
    // R1: input changes without an edge do nothing
    d = 4'b0110; load_par = 1; j = 1; kn = 0; #2 chk("R1", m);
    @(posedge clk); m = 4'b0110; #3 chk("R3", m); #2;
    // R7 reset between edges, held across a load edge
    #1 rst = 1; m = 0; #1 chk("R7", 4'b0000);
    load_par = 1; d = 4'b1111;
    @(posedge clk); #3 chk("R7", 4'b0000);
    true_out = 0; #1 chk("R7", 4'b1111);
    @(negedge clk); rst = 0; true_out = 1;
    step("R3", 1, 0, 0, 4'b0011);
    step("R2", 0, 1, 1, 4'b0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule